// File: doc/BRIEF.md
# Key-Unlocked Flash Program Controller

This block lets a CPU reprogram a 24-bit-wide flash array while it runs. Software writes over a simple register bus. It fills a bank of holding latches, and each 24-bit latch takes two writes: a 16-bit low part and an 8-bit high part. Software then sets a destination word address and chooses an operation. The operation is either programming one word, programming one whole row, or erasing one whole page.

The start bit is guarded by a key. The key register must first receive 0x55 and then 0xAA as the next bus write. That opens a start window two cycles long. A start request outside the window, or one without the enable bit, is refused and sets a sticky key-error flag.

An accepted operation holds the stall output high for a fixed number of cycles, and the array contents change as stall falls. A small internal array stands in for the flash. Erased words read as all ones. Programming can only clear bits. Programming the same word twice without an erase sets a sticky program-error flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The window opens only when a key write of 0x55 (register 0x02, data bits 7:0) is followed, as the very next bus write, by a key write of 0xAA. The reversed order, wrong values, or any other bus write in between all leave the start bit locked.
- R2: A control write with the start bit set is accepted if its clock edge is the first or second edge after the 0xAA write's edge. The same write on the third edge is refused.
- R3: The control register is at 0x02 minus one, that is 0x01. Its bits 1:0 select the operation: 01 programs a word, 10 programs a row, 11 erases a page. Bit 2 is the write enable and bit 15 is the start bit. A start with the enable bit clear, or with operation 00, is refused and nothing is written.
- R4: Latch i takes a low write at bus address 0x80+2i, which sets data bits 15:0. It takes a high write at 0x81+2i, which sets bits 23:16 from data bits 7:0. Neither part disturbs the other. Latches reset to 0xFFFFFF.
- R5: A word program ANDs latch 0 into the flash word at the destination address. The destination address is register 0x00.
- R6: A row program ANDs latch i into word rowbase+i for every i. Rowbase is the destination address with its low log2(ROW_WORDS) bits cleared. Words outside the row are unchanged.
- R7: A page erase sets every word of the page that holds the destination address to 0xFFFFFF. The page base is the address with its low log2(PAGE_WORDS) bits cleared. Other pages are unchanged.
- R8: Stall rises on the edge that accepts the start. It then stays high for exactly PROG_CYC cycles for a word or row program, and exactly ERASE_CYC cycles for an erase. The new contents can be read once stall is low.
- R9: Programming a word that was already programmed since its last erase sets prog_err. The word still ends up holding the AND. prog_err stays set until the next page erase or a reset.
- R10: A refused start sets key_err, and key_err stays set until reset.
- R11: After reset, stall, key_err and prog_err are 0, and every flash word reads 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address; bit 7 selects the latch window |
| bus_wdata | input | 16 | Write data |
| rd_addr | input | ADDR_W | Flash read address |
| rd_data | output | 24 | Flash word at rd_addr |
| stall | output | 1 | CPU stall while an operation runs |
| key_err | output | 1 | Sticky refused-start flag |
| prog_err | output | 1 | Sticky double-program flag |

## Verification
Suppose the key tracker holds a wrong state. A refused start would then raise stall on the very next edge, or an accepted start would leave stall low and raise key_err, so the fault shows one cycle after the control write. A wrong countdown shows as a stall pulse of the wrong length, measured to the cycle. A wrong row or page base shows as words changed outside the target, or left unchanged inside it, when the array is read back right after stall falls. Used-word tracking errors show as prog_err out of step with a reference model during a long random run of word programs.

// File: rtl/fpc_pkg.sv
// Shared encodings for the flash program controller.
package fpc_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WORD  = 2'b01,
        OP_ROW   = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    localparam logic [7:0]  SEL_DEST  = 8'h00;
    localparam logic [7:0]  SEL_CTRL  = 8'h01;
    localparam logic [7:0]  SEL_KEY   = 8'h02;
    localparam logic [7:0]  KEY_FIRST = 8'h55;
    localparam logic [7:0]  KEY_SECOND = 8'hAA;
    localparam int          CTRL_GO   = 15;
    localparam int          CTRL_EN   = 2;
    localparam logic [23:0] BLANK     = 24'hFFFFFF;
endpackage

// File: rtl/fpc_key_gate.sv
// Tracks the two-value key and opens the start window.
// Assumes: one bus write per cycle at most; any control write closes the window.
module fpc_key_gate
    import fpc_pkg::*;
#(
    parameter int WIN_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_wr,
    input  logic       key_wr,
    input  logic       ctrl_wr,
    input  logic [7:0] key_val,
    output logic       win_open
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic          armed;
    logic [CW-1:0] win_cnt;

    // Arm on the first key value, open on the second, count the window down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            win_cnt <= '0;
        end else if (key_wr) begin
            armed   <= (key_val == KEY_FIRST);
            win_cnt <= (armed && key_val == KEY_SECOND) ? CW'(WIN_CYC) : '0;
        end else begin
            if (any_wr) armed <= 1'b0;
            if (ctrl_wr) win_cnt <= '0;
            else if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
        end
    end

    assign win_open = (win_cnt != '0);

    // R1
    win_from_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(key_wr && key_val == KEY_SECOND));
endmodule

// File: rtl/fpc_latch_bank.sv
// Holding latches; each 24-bit entry is assembled from a low and a high write.
// Assumes: idx beyond ROW_WORDS is ignored.
module fpc_latch_bank
    import fpc_pkg::*;
#(
    parameter int ROW_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [5:0]                  idx,
    input  logic                        hi,
    input  logic [15:0]                 wdata,
    output logic [ROW_WORDS-1:0][23:0]  lat
);
    for (genvar i = 0; i < ROW_WORDS; i++) begin : g_lat
        logic hit;
        assign hit = wr_en && (idx == 6'(i));

        // Update the selected half of latch i.
        always_ff @(posedge clk) begin
            if (!rst_n)        lat[i] <= BLANK;
            else if (hit && hi)  lat[i][23:16] <= wdata[7:0];
            else if (hit)        lat[i][15:0]  <= wdata;
        end

        // R4
        low_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !hi) |=> lat[i][23:16] == $past(lat[i][23:16]));
    end
endmodule

// File: rtl/fpc_flash_array.sv
// Word array model: erase to all ones, program by AND, flags reprogramming.
// Assumes: at most one of do_word/do_row/do_erase per cycle.
module fpc_flash_array
    import fpc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ROW_WORDS  = 8,
    parameter int PAGE_WORDS = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       do_word,
    input  logic                       do_row,
    input  logic                       do_erase,
    input  logic [ADDR_W-1:0]          tgt,
    input  logic [ROW_WORDS-1:0][23:0] lat,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [23:0]                rd_data,
    output logic                       prog_err
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int ROW_LG  = $clog2(ROW_WORDS);
    localparam int PAGE_LG = $clog2(PAGE_WORDS);

    logic [23:0]      mem  [DEPTH];
    logic [DEPTH-1:0] used;
    logic [ADDR_W-1:0] row_base, page_base;
    logic [23:0]      old_w;

    assign row_base  = {tgt[ADDR_W-1:ROW_LG], {ROW_LG{1'b0}}};
    assign page_base = {tgt[ADDR_W-1:PAGE_LG], {PAGE_LG{1'b0}}};
    assign old_w     = mem[tgt];
    assign rd_data   = mem[rd_addr];

    // Apply erase or program and keep the used-since-erase map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= BLANK;
            used     <= '0;
            prog_err <= 1'b0;
        end else if (do_erase) begin
            for (int p = 0; p < PAGE_WORDS; p++) begin
                mem[page_base | ADDR_W'(p)]  <= BLANK;
                used[page_base | ADDR_W'(p)] <= 1'b0;
            end
            prog_err <= 1'b0;
        end else if (do_word) begin
            mem[tgt]  <= old_w & lat[0];
            used[tgt] <= 1'b1;
            if (used[tgt]) prog_err <= 1'b1;
        end else if (do_row) begin
            for (int r = 0; r < ROW_WORDS; r++) begin
                mem[row_base | ADDR_W'(r)]  <= mem[row_base | ADDR_W'(r)] & lat[r];
                used[row_base | ADDR_W'(r)] <= 1'b1;
                if (used[row_base | ADDR_W'(r)]) prog_err <= 1'b1;
            end
        end
    end

    // R5
    word_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_word |=> mem[$past(tgt)] == ($past(old_w) & $past(lat[0])));
    // R7
    erase_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_erase |=> (mem[$past(page_base)] == BLANK) && !prog_err);
    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !do_erase) |=> prog_err);
endmodule

// File: rtl/flash_prog_ctrl.sv
// Top: register decode, start gating and the operation countdown.
// Assumes: bus writes while stall is high are dropped.
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ROW_WORDS  = 8,
    parameter int PAGE_WORDS = 64,
    parameter int PROG_CYC   = 16,
    parameter int ERASE_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [23:0]       rd_data,
    output logic              stall,
    output logic              key_err,
    output logic              prog_err
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic                       wr, key_wr, ctrl_wr, dest_wr, lat_wr;
    logic                       win_open, start_req, go;
    op_e                        op_req, op_q;
    logic [CW-1:0]              cnt;
    logic [ADDR_W-1:0]          dest;
    logic                       fin;
    logic [ROW_WORDS-1:0][23:0] lat;

    assign wr        = bus_we && !stall;
    assign key_wr    = wr && bus_addr == SEL_KEY;
    assign ctrl_wr   = wr && bus_addr == SEL_CTRL;
    assign dest_wr   = wr && bus_addr == SEL_DEST;
    assign lat_wr    = wr && bus_addr[7];
    assign op_req    = op_e'(bus_wdata[1:0]);
    assign start_req = ctrl_wr && bus_wdata[CTRL_GO];
    assign go        = start_req && win_open && bus_wdata[CTRL_EN] && op_req != OP_NONE;
    assign fin       = stall && cnt == CW'(1);

    fpc_key_gate #(.WIN_CYC(2)) u_key (
        .clk(clk), .rst_n(rst_n), .any_wr(wr), .key_wr(key_wr),
        .ctrl_wr(ctrl_wr), .key_val(bus_wdata[7:0]), .win_open(win_open)
    );

    fpc_latch_bank #(.ROW_WORDS(ROW_WORDS)) u_lat (
        .clk(clk), .rst_n(rst_n), .wr_en(lat_wr), .idx(bus_addr[6:1]),
        .hi(bus_addr[0]), .wdata(bus_wdata), .lat(lat)
    );

    fpc_flash_array #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS), .PAGE_WORDS(PAGE_WORDS)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .do_word(fin && op_q == OP_WORD), .do_row(fin && op_q == OP_ROW),
        .do_erase(fin && op_q == OP_ERASE), .tgt(dest), .lat(lat),
        .rd_addr(rd_addr), .rd_data(rd_data), .prog_err(prog_err)
    );

    // Hold the destination address.
    always_ff @(posedge clk) begin
        if (!rst_n)       dest <= '0;
        else if (dest_wr) dest <= bus_wdata[ADDR_W-1:0];
    end

    // Launch, count down and finish an operation; flag refused starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall   <= 1'b0;
            cnt     <= '0;
            op_q    <= OP_NONE;
            key_err <= 1'b0;
        end else if (go) begin
            stall <= 1'b1;
            op_q  <= op_req;
            cnt   <= (op_req == OP_ERASE) ? CW'(ERASE_CYC) : CW'(PROG_CYC);
        end else begin
            if (start_req) key_err <= 1'b1;
            if (fin)        stall <= 1'b0;
            else if (stall) cnt   <= cnt - 1'b1;
        end
    end

    // R8
    go_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> stall);
    // R8
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && cnt != CW'(1)) |=> stall);
    // R10
    kerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |=> key_err);
    // R2
    go_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(win_open));
endmodule

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
    localparam int AW = 8, RW = 8, PW = 64, PC = 16, EC = 64;

    logic clk = 0, rst_n = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [23:0] rd_data;
    logic stall, key_err, prog_err;

    flash_prog_ctrl #(.ADDR_W(AW), .ROW_WORDS(RW), .PAGE_WORDS(PW),
                      .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .stall(stall), .key_err(key_err), .prog_err(prog_err));

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    logic [23:0] mf [256];
    logic        mu [256];
    logic [23:0] ml [RW];
    logic        m_perr = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_lat(int i, logic [23:0] v);
        wr(8'h80 + 8'(2 * i), v[15:0]);
        wr(8'h81 + 8'(2 * i), {8'h00, v[23:16]});
        ml[i] = v;
    endtask

    task automatic rd_chk(string req, int a);
        rd_addr = AW'(a);
        #1;
        chk(req, rd_data, mf[a]);
    endtask

    function automatic void m_word(int a);
        if (mu[a]) m_perr = 1;
        mf[a] = mf[a] & ml[0];
        mu[a] = 1;
    endfunction

    function automatic void m_row(int a);
        int b = a & ~(RW - 1);
        for (int r = 0; r < RW; r++) begin
            if (mu[b + r]) m_perr = 1;
            mf[b + r] = mf[b + r] & ml[r];
            mu[b + r] = 1;
        end
    endfunction

    function automatic void m_erase(int a);
        int b = a & ~(PW - 1);
        for (int p = 0; p < PW; p++) begin
            mf[b + p] = 24'hFFFFFF;
            mu[b + p] = 0;
        end
        m_perr = 0;
    endfunction

    // Unlock, start op, measure stall length, update model.
    task automatic run_op(int a, logic [1:0] op, string req);
        int n = 0;
        int exp = (op == 2'b11) ? EC : PC;
        wr(8'h00, 16'(a));
        wr(8'h02, 16'h0055);
        wr(8'h02, 16'h00AA);
        wr(8'h01, 16'h8004 | {14'h0, op});
        while (stall && n < 1000) begin n++; @(negedge clk); end
        chk({req, " R8 stall cycles"}, n, exp);
        if (op == 2'b01) m_word(a);
        else if (op == 2'b10) m_row(a);
        else m_erase(a);
        chk({req, " R9 prog_err"}, prog_err, m_perr);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 256; a++) begin mf[a] = 24'hFFFFFF; mu[a] = 0; end
        for (int i = 0; i < RW; i++) ml[i] = 24'hFFFFFF;
        idle(3);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        chk("R11 stall", stall, 0);
        chk("R11 key_err", key_err, 0);
        chk("R11 prog_err", prog_err, 0);
        rd_chk("R11 blank word", 5);

        // R4, R5: assemble latch 0 high first then low, program word
        wr(8'h81, 16'h00AB);
        wr(8'h80, 16'h1234);
        ml[0] = 24'hAB1234;
        run_op(17, 2'b01, "R5");
        rd_chk("R4 R5 word 17", 17);
        rd_chk("R5 neighbour 18", 18);

        // R6: row program, address not row aligned
        for (int i = 0; i < RW; i++) set_lat(i, 24'($urandom));
        run_op(8'h2B, 2'b10, "R6");
        for (int a = 8'h27; a <= 8'h30; a++) rd_chk("R6 row area", a);

        // R9: reprogram word 17
        set_lat(0, 24'h0F0F0F);
        run_op(17, 2'b01, "R9");
        chk("R9 flag set", prog_err, 1);
        rd_chk("R9 AND result", 17);

        // R7: word in page 1, then erase page 0
        set_lat(0, 24'h00FF00);
        run_op(8'h50, 2'b01, "R7 setup");
        run_op(8'h15, 2'b11, "R7");
        rd_chk("R7 page0 first", 0);
        rd_chk("R7 page0 word17", 17);
        rd_chk("R7 page0 last", 63);
        rd_chk("R7 page1 kept", 8'h50);
        chk("R9 cleared by erase", prog_err, 0);

        // R2: start on second edge after key accepted
        set_lat(0, 24'h000001);
        wr(8'h00, 16'd3);
        wr(8'h02, 16'h0055);
        wr(8'h02, 16'h00AA);
        idle(1);
        wr(8'h01, 16'h8005);
        chk("R2 second-edge accepted", stall, 1);
        while (stall) @(negedge clk);
        m_word(3);
        rd_chk("R2 word 3", 3);
        chk("R2 no key_err", key_err, 0);

        // R2: third edge refused
        wr(8'h00, 16'd4);
        wr(8'h02, 16'h0055);
        wr(8'h02, 16'h00AA);
        idle(2);
        wr(8'h01, 16'h8005);
        chk("R2 third-edge refused", stall, 0);
        chk("R10 key_err set", key_err, 1);
        idle(PC + 2);
        rd_chk("R2 word 4 untouched", 4);

        // R1: reversed order
        wr(8'h02, 16'h00AA);
        wr(8'h02, 16'h0055);
        wr(8'h01, 16'h8005);
        chk("R1 reversed refused", stall, 0);
        // R1: other write between keys
        wr(8'h02, 16'h0055);
        wr(8'h00, 16'd4);
        wr(8'h02, 16'h00AA);
        wr(8'h01, 16'h8005);
        chk("R1 interleaved refused", stall, 0);
        // R1: wrong second value
        wr(8'h02, 16'h0055);
        wr(8'h02, 16'h00AB);
        wr(8'h01, 16'h8005);
        chk("R1 wrong value refused", stall, 0);
        idle(PC + 2);
        rd_chk("R1 word 4 untouched", 4);

        // R3: enable clear, and op none
        wr(8'h02, 16'h0055);
        wr(8'h02, 16'h00AA);
        wr(8'h01, 16'h8001);
        chk("R3 no enable refused", stall, 0);
        wr(8'h02, 16'h0055);
        wr(8'h02, 16'h00AA);
        wr(8'h01, 16'h8004);
        chk("R3 op none refused", stall, 0);
        idle(PC + 2);
        rd_chk("R3 word 4 untouched", 4);

        // R10: key_err stays after good op; random word programs in pages 2-3
        for (int k = 0; k < 40; k++) begin
            int a = 128 + int'($urandom % 128);
            set_lat(0, 24'($urandom));
            if (k % 13 == 12) run_op(a, 2'b11, "R7 rand");
            else run_op(a, 2'b01, "R5 rand");
            rd_chk("R5 R9 rand word", a);
        end
        chk("R10 key_err sticky", key_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule